// File: doc/BRIEF.md
# Four-Channel Power-of-Two PWM Timer

This block is a pulse-width modulation timer for a peripheral subsystem. A single free-running counter is shared by four compare channels. A four-bit scale setting picks which 16-bit window of the counter the channels compare against. The period is therefore always a power of two input clock ticks, from 2^16 up to 2^31. Each channel holds its own 16-bit threshold and drives one output pin. The pin is high while the scaled count is at or above that threshold, so the output is inverted with respect to the compare value.

Software drives the block through a plain synchronous read/write port. Reads are combinational and writes take effect on the next clock edge. There is no shadowing. A new scale or a new threshold acts on the very next cycle, so one period may mix the old setting with the new one.

Top module: `pwmt_top`

## Requirements
- R1: After a synchronous active-low reset, the counter, the config register and all four compare registers read zero, and every output is low.
- R2: Register map (byte offsets on `bus_addr`):
  - config at 0x00, holding the scale in bits [3:0] and the run bit in bit 12; all other config bits read zero.
  - raw count at 0x08.
  - scaled count at 0x10.
  - compare n at 0x20 + 4*n, holding bits [15:0] only.
  - any other offset reads zero.
- R3: While the run bit is 1, the counter advances by one every clock. While it is 0, the counter holds its value.
- R4: The counter is 31 bits wide and wraps from 0x7FFFFFFF to 0. A write to the raw count offset loads the written value and takes priority over counting.
- R5: The scaled count equals bits [scale+15:scale] of the counter.
- R6: Output n is registered. In the cycle after the counter holds a value, output n is 1 if that value's scaled count is greater than or equal to compare n, and 0 otherwise. A compare of 0 keeps the output constantly high while running. One period lasts 2^(16+scale) clocks.
- R7: With compare 0xFFFF, the output is high for exactly one scaled-count value per period (0xFFFF), so no compare value gives a constant low output while running.
- R8: While the run bit is 0, all four outputs are low regardless of the compare values.
- R9: A write to the scale field or to a compare register affects the output one cycle later, without waiting for a period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pwm_out | output | 4 | Channel outputs, bit n for channel n |

## Verification
The hardest situations to reach from the ports are the top of long periods and the counter wrap. At scale 15 these lie about 2^31 cycles away. The stimulus reaches them by loading the raw count through its write offset, just below the slice of interest, and then checking the output one cycle later. A single full period at scale 0 is also run to completion, counting high cycles, to confirm the duty fraction. Mid-period writes to the scale and compare registers show that a change lands on the next cycle rather than at a period boundary.

// File: rtl/pwmt_pkg.sv
// Package: register offsets and config field positions shared by the timer.
// Assumes byte addressing with 32-bit registers on a simple synchronous port.
package pwmt_pkg;
    localparam int OFF_CFG     = 'h00;
    localparam int OFF_RAW     = 'h08;
    localparam int OFF_SCALED  = 'h10;
    localparam int OFF_CMP0    = 'h20;
    localparam int CMP_STRIDE  = 4;
    localparam int CFG_RUN_BIT = 12;
endpackage

// File: rtl/pwmt_regfile.sv
// Register file: config and compare storage, raw-count load request, read mux.
// Assumes writes are single-cycle strobes and reads are combinational.
module pwmt_regfile
    import pwmt_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = CMP_W + (1 << SCALE_W) - 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    input  logic [CNT_W-1:0]              cnt,
    input  logic [CMP_W-1:0]              scaled,
    output logic [SCALE_W-1:0]            scale,
    output logic                          run,
    output logic [NUM_CH-1:0][CMP_W-1:0]  cmp,
    output logic                          cnt_ld,
    output logic [CNT_W-1:0]              cnt_ld_val
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];

    // Decode the raw-count load request.
    assign cnt_ld     = wr && (addr == ADDR_W'(OFF_RAW));
    assign cnt_ld_val = wdata[CNT_W-1:0];

    // Hold config fields; only scale and run bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale <= '0;
            run   <= 1'b0;
        end else if (wr && addr == ADDR_W'(OFF_CFG)) begin
            scale <= wdata[SCALE_W-1:0];
            run   <= wdata[CFG_RUN_BIT];
        end
    end

    // Hold the per-channel compare values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
        end else begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (wr && addr == ADDR_W'(OFF_CMP0 + n * CMP_STRIDE))
                    cmp[n] <= wdata[CMP_W-1:0];
            end
        end
    end

    // Select read data by offset; unmapped offsets give zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_CFG)) begin
            rdata[SCALE_W-1:0]  = scale;
            rdata[CFG_RUN_BIT]  = run;
        end else if (addr == ADDR_W'(OFF_RAW)) begin
            rdata = DATA_W'(cnt);
        end else if (addr == ADDR_W'(OFF_SCALED)) begin
            rdata = DATA_W'(scaled);
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ADDR_W'(OFF_CMP0 + n * CMP_STRIDE))
                rdata = DATA_W'(cmp[n]);
        end
    end

    AST_CMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> cmp == $past(cmp)); // R9
    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> (scale == $past(scale)) && (run == $past(run))); // R2
endmodule

// File: rtl/pwmt_counter.sv
// Counter: free-running up counter with load, plus the scaled 16-bit window.
// Assumes CNT_W = CMP_W + 2^SCALE_W - 1 so every window fits the counter.
module pwmt_counter #(
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4,
    parameter int CNT_W   = CMP_W + (1 << SCALE_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    input  logic               ld,
    input  logic [CNT_W-1:0]   ld_val,
    output logic [CNT_W-1:0]   cnt,
    output logic [CMP_W-1:0]   scaled
);
    // Advance, load or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (ld)   cnt <= ld_val;
        else if (run)  cnt <= cnt + 1'b1;
    end

    // Pick the compare window selected by scale.
    assign scaled = CMP_W'(cnt >> scale);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld) |=> cnt == $past(cnt)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R4
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt == $past(ld_val)); // R4
endmodule

// File: rtl/pwmt_channel.sv
// Channel: registered comparator of the scaled count against one threshold.
// Assumes the output is forced low whenever the timer is not running.
module pwmt_channel #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] cmp,
    output logic             out
);
    // Register the compare result, gated by the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) out <= 1'b0;
        else        out <= run && (scaled >= cmp);
    end

    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !out); // R8
    AST_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cmp == '0) |=> out); // R6
    AST_OUT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp == '1 && scaled != '1) |=> !out); // R7
endmodule

// File: rtl/pwmt_top.sv
// Top: four-channel PWM timer with power-of-two period selection.
// Assumes a single clock domain and a simple synchronous register port.
module pwmt_top #(
    parameter int NUM_CH  = 4,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;

    logic [SCALE_W-1:0]           scale;
    logic                         run;
    logic [NUM_CH-1:0][CMP_W-1:0] cmp;
    logic                         cnt_ld;
    logic [CNT_W-1:0]             cnt_ld_val;
    logic [CNT_W-1:0]             cnt;
    logic [CMP_W-1:0]             scaled;

    pwmt_regfile #(
        .NUM_CH(NUM_CH), .CMP_W(CMP_W), .SCALE_W(SCALE_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt), .scaled(scaled),
        .scale(scale), .run(run), .cmp(cmp),
        .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val)
    );

    pwmt_counter #(
        .CMP_W(CMP_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .scale(scale),
        .ld(cnt_ld), .ld_val(cnt_ld_val), .cnt(cnt), .scaled(scaled)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwmt_channel #(.CMP_W(CMP_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run), .scaled(scaled),
            .cmp(cmp[n]), .out(pwm_out[n])
        );
    end

    AST_RST_QUIET: assert property (@(posedge clk)
        !rst_n |=> pwm_out == '0); // R1
endmodule

// File: tb/pwmt_top_bench.sv
`timescale 1ns/1ps
module pwmt_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwmt_top u_pwmt_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [3:0]  scale;
        logic [30:0] pre;
        logic [15:0] cmp;
        logic        exp;
    } vec_t;

    // scale, counter preload, compare, expected output one cycle later
    localparam vec_t VECS [8] = '{
        '{4'd0,  31'h0000_0100, 16'h0200, 1'b0},
        '{4'd0,  31'h0000_0300, 16'h0200, 1'b1},
        '{4'd4,  31'h0001_2340, 16'h1234, 1'b1},
        '{4'd4,  31'h0001_233F, 16'h1234, 1'b0},
        '{4'd15, 31'h7FFF_8000, 16'hFFFF, 1'b1},
        '{4'd15, 31'h7FFF_0000, 16'hFFFF, 1'b0},
        '{4'd8,  31'h00FF_FF00, 16'h0000, 1'b1},
        '{4'd1,  31'h0001_FFFE, 16'hFFFF, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #0.5;
        d = bus_rdata;
    endtask

    task automatic step;
        @(posedge clk); #1;
    endtask

    initial begin
        #(5.0 * 190000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int hi;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 out", {28'd0, pwm_out}, 32'd0);
        rd(8'h00, r); chk("R1 cfg", r, 0);
        rd(8'h08, r); chk("R1 raw", r, 0);
        rd(8'h10, r); chk("R1 scaled", r, 0);
        for (int n = 0; n < 4; n++) begin
            rd(8'(8'h20 + 4 * n), r); chk("R1 cmp", r, 0);
        end

        // R2 map and field widths
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, r); chk("R2 cfg fields", r, 32'h0000_100F);
        wr(8'h00, 32'h0);
        wr(8'h2C, 32'h1234_ABCD);
        rd(8'h2C, r); chk("R2 cmp3 width", r, 32'h0000_ABCD);
        rd(8'h04, r); chk("R2 unmapped 04", r, 0);
        rd(8'h30, r); chk("R2 unmapped 30", r, 0);

        // R8 idle outputs and R3 hold
        for (int n = 0; n < 4; n++) wr(8'(8'h20 + 4 * n), 32'h0);
        wr(8'h08, 32'h55);
        repeat (5) step();
        rd(8'h08, r); chk("R3 hold", r, 32'h55);
        chk("R8 idle low", {28'd0, pwm_out}, 32'd0);

        // R3 advance, R6 zero compare gives high
        wr(8'h00, 32'h1000);
        repeat (10) step();
        rd(8'h08, r); chk("R3 advance", r, 32'h5F);
        chk("R6 cmp zero high", {28'd0, pwm_out}, 32'hF);

        // R4 wrap
        wr(8'h08, 32'h7FFF_FFFF);
        step();
        rd(8'h08, r); chk("R4 wrap", r, 0);

        // R5 R6 vector table
        for (int i = 0; i < 8; i++) begin
            int ch = i % 4;
            logic [30:0] nxt;
            wr(8'h00, 32'h1000 | 32'(VECS[i].scale));
            wr(8'(8'h20 + 4 * ch), 32'(VECS[i].cmp));
            wr(8'h08, 32'(VECS[i].pre));
            step();
            chk("R6 vector out", {31'd0, pwm_out[ch]}, {31'd0, VECS[i].exp});
            nxt = VECS[i].pre + 31'd1;
            rd(8'h10, r);
            chk("R5 scaled", r, 32'((nxt >> VECS[i].scale) & 31'hFFFF));
        end

        // R7 compare max: high only at scaled 0xFFFF
        wr(8'h00, 32'h1000);
        wr(8'h20, 32'hFFFF);
        wr(8'h08, 32'h0000_FFFE);
        step(); chk("R7 below max", {31'd0, pwm_out[0]}, 0);
        step(); chk("R7 at max", {31'd0, pwm_out[0]}, 1);
        step(); chk("R7 after wrap", {31'd0, pwm_out[0]}, 0);

        // R9 compare change acts next cycle
        wr(8'h24, 32'h20);
        wr(8'h08, 32'h10);
        step(); chk("R9 before cmp write", {31'd0, pwm_out[1]}, 0);
        wr(8'h24, 32'h08);
        step(); chk("R9 cmp immediate", {31'd0, pwm_out[1]}, 1);
        // R9 scale change acts next cycle
        wr(8'h24, 32'h100);
        wr(8'h08, 32'h1000);
        step(); chk("R9 before scale write", {31'd0, pwm_out[1]}, 1);
        wr(8'h00, 32'h1008);
        step(); chk("R9 scale immediate", {31'd0, pwm_out[1]}, 0);

        // R6 full period duty at scale 0
        wr(8'h00, 32'h1000);
        wr(8'h28, 32'h4000);
        wr(8'h08, 32'h0);
        hi = 0;
        for (int k = 0; k < 65536; k++) begin
            step();
            if (pwm_out[2]) hi++;
        end
        chk("R6 duty count", 32'(hi), 32'd49152);

        // R8 stopping forces low
        wr(8'h00, 32'h0);
        step();
        chk("R8 stop low", {28'd0, pwm_out}, 0);

        // R1 reset again clears state
        @(negedge clk) rst_n = 1'b0;
        step();
        #1 rst_n = 1'b1;
        rd(8'h28, r); chk("R1 cmp after reset", r, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule